// File: doc/BRIEF.md
# Multi-Size Set-Associative Translation Cache

This block caches virtual-to-physical translations for 4 KiB, 64 KiB and 1 MiB pages in an array of 64 sets by 8 ways. A lookup port takes a full virtual address. One cycle later the block returns a result flag, a hit flag, a flag that reports more than one matching way, and the translated physical address. A page-table walker outside the block installs translations through a fill port. Software-driven maintenance uses two strobes: one clears every entry, and the other clears the entries of one page within one set.

The set is always chosen from virtual address bits [17:12], whatever the page size. A large entry therefore lives only in the set of the address that caused its fill, so the same 64 KiB page can be cached in up to 16 sets and the same 1 MiB page in up to 64 sets. Removing a large page fully needs one per-page invalidation for every set it could occupy. Duplicate fills are not filtered, and overlapping entries are reported as a multi-hit.

Replacement takes the lowest-numbered invalid way first. When the set is full, a configuration input selects between least-recently-used replacement and a single rotating pointer.

Top module: `xlate_tlb`

## Requirements
- R1: While reset is high and in the cycle after it falls, `lk_valid`, `lk_hit` and `lk_multi` are low, and every entry is invalid, so a first lookup misses.
- R2: A lookup presented in cycle N gives `lk_valid` high in cycle N+1 only. `lk_pa` is the entry's frame, with the low frame bits replaced by virtual page bits for large pages (4 bits for 64 KiB, 8 bits for 1 MiB), concatenated with `lookup_va[11:0]`.
- R3: The set is `lookup_va[17:12]` for lookups and the low 6 bits of `fill_vpn`/`inv_vpn` for fills and invalidations. An entry of any size is found only through an address whose bits [17:12] equal those of its fill address.
- R4: Size codes on `fill_size` are 0 for 4 KiB, 1 for 64 KiB and 2 for 1 MiB. A fill with code 3 changes nothing.
- R5: When more than one valid way in the set matches, `lk_hit` and `lk_multi` are both high and `lk_pa` comes from the lowest-numbered matching way.
- R6: A page invalidation clears every valid way of the set selected by `inv_vpn` whose stored tag equals `inv_vpn` masked to that entry's size. Entries in other sets are left untouched.
- R7: `inv_all` clears every entry in one cycle, and a fill in the same cycle is dropped.
- R8: A fill writes the lowest-numbered invalid way of its set if one exists.
- R9: With `cfg_lru` = 1 and a full set, a fill replaces the way used least recently. Lookup hits and fills count as uses.
- R10: With `cfg_lru` = 0 and a full set, a fill replaces the way named by one global pointer, which starts at 0 after reset and advances by one after each such replacement.
- R11: A lookup sees the array as it stood before any fill or invalidation in the same cycle. A fill in the same cycle as a page invalidation that matches it is still installed.
- R12: A 1 MiB entry cached in several sets is removed from all of them only by per-page invalidations that cover each of those sets. A 1 MiB region needs 64 of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_lru | input | 1 | 1: least-recently-used victim, 0: rotating pointer |
| lookup_req | input | 1 | Lookup strobe |
| lookup_va | input | 32 | Virtual address to translate |
| lk_valid | output | 1 | Lookup result present |
| lk_hit | output | 1 | At least one way matched |
| lk_multi | output | 1 | More than one way matched |
| lk_pa | output | 32 | Translated physical address |
| fill_req | input | 1 | Fill strobe |
| fill_vpn | input | 20 | Virtual page number of the access that was walked |
| fill_pfn | input | 20 | Physical frame base of the translation |
| fill_size | input | 2 | Page size code |
| inv_all | input | 1 | Clear all entries |
| inv_page | input | 1 | Per-page invalidation strobe |
| inv_vpn | input | 20 | Page number to invalidate |

## Verification
The lookup can coincide with either maintenance operation or with a fill, because all of them act in the same cycle. The bench drives a lookup together with a matching page invalidation, and separately a lookup together with a fill of the same page. The same-cycle result must reflect the old contents, and a lookup in the following cycle must reflect the new contents. It also drives a fill and a matching page invalidation together, and the fill must be the one that survives.

// File: rtl/xlate_tlb_pkg.sv
package xlate_tlb_pkg;
    parameter int VA_W      = 32;
    parameter int OFF_W     = 12;
    parameter int VPN_W     = VA_W - OFF_W;
    parameter int TLB_SETS  = 64;
    parameter int TLB_WAYS  = 8;
    parameter int MID_BITS  = 4;   // 64 KiB / 4 KiB
    parameter int SECT_BITS = 8;   // 1 MiB / 4 KiB

    typedef enum logic [1:0] {
        SZ_SMALL = 2'd0,
        SZ_MID   = 2'd1,
        SZ_SECT  = 2'd2,
        SZ_RSVD  = 2'd3
    } size_e;

    typedef struct packed {
        logic             valid;
        size_e            size;
        logic [VPN_W-1:0] tag;
        logic [VPN_W-1:0] pfn;
    } entry_t;

    // Page-number bits that belong to the page (kept) for a size code.
    function automatic logic [VPN_W-1:0] size_mask(input size_e sz);
        logic [VPN_W-1:0] m;
        m = '1;
        if (sz == SZ_MID)  m[MID_BITS-1:0]  = '0;
        if (sz == SZ_SECT) m[SECT_BITS-1:0] = '0;
        return m;
    endfunction
endpackage

// File: rtl/xlate_tlb_match.sv
module xlate_tlb_match
    import xlate_tlb_pkg::*;
#(
    parameter int WAYS = TLB_WAYS
) (
    input  entry_t [WAYS-1:0] ents,
    input  logic [VPN_W-1:0]  vpn,
    output logic [WAYS-1:0]   hit_vec
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = ents[w].valid &&
                            ((vpn & size_mask(ents[w].size)) == ents[w].tag);
    end
endmodule

// File: rtl/xlate_tlb_age.sv
module xlate_tlb_age #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] age_in,
    input  logic                       touch,
    input  logic [WAY_W-1:0]           way,
    output logic [WAYS-1:0][WAY_W-1:0] age_out
);
    for (genvar w = 0; w < WAYS; w++) begin : g_age
        always_comb begin
            age_out[w] = age_in[w];
            if (touch) begin
                if (WAY_W'(w) == way)
                    age_out[w] = '0;
                else if (age_in[w] < age_in[way])
                    age_out[w] = age_in[w] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlate_tlb_victim.sv
module xlate_tlb_victim #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid_vec,
    input  logic [WAYS-1:0][WAY_W-1:0] ages,
    input  logic                       lru_mode,
    input  logic [WAY_W-1:0]           rr_ptr,
    output logic [WAY_W-1:0]           way,
    output logic                       use_rr
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic             have_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] old_way;

    always_comb begin
        have_free = 1'b0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                have_free = 1'b1;
                free_way  = WAY_W'(w);
            end
        end
    end

    always_comb begin
        old_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (ages[w] == OLDEST) old_way = WAY_W'(w);
    end

    always_comb begin
        use_rr = 1'b0;
        if (have_free)
            way = free_way;
        else if (lru_mode)
            way = old_way;
        else begin
            way    = rr_ptr;
            use_rr = 1'b1;
        end
    end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xlate_tlb_pkg::*;
#(
    parameter int SETS = TLB_SETS,
    parameter int WAYS = TLB_WAYS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_lru,
    input  logic             lookup_req,
    input  logic [VA_W-1:0]  lookup_va,
    output logic             lk_valid,
    output logic             lk_hit,
    output logic             lk_multi,
    output logic [VA_W-1:0]  lk_pa,
    input  logic             fill_req,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [VPN_W-1:0] fill_pfn,
    input  logic [1:0]       fill_size,
    input  logic             inv_all,
    input  logic             inv_page,
    input  logic [VPN_W-1:0] inv_vpn
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int CNT_W = WAY_W + 1;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             multi;
        logic [VA_W-1:0]  pa;
        logic [WAY_W-1:0] rr;
    } ctl_t;

    entry_t [WAYS-1:0]            ent_q [SETS];
    entry_t [WAYS-1:0]            ent_d [SETS];
    logic [WAYS-1:0][WAY_W-1:0]   age_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0]   age_d [SETS];
    ctl_t                         st_q, st_d;

    // Set selection: always the low page-number bits (R3)
    logic [SET_W-1:0] lk_set, fl_set, iv_set;
    logic [VPN_W-1:0] lk_vpn;
    assign lk_vpn = lookup_va[VA_W-1:OFF_W];
    assign lk_set = lk_vpn[SET_W-1:0];
    assign fl_set = fill_vpn[SET_W-1:0];
    assign iv_set = inv_vpn[SET_W-1:0];

    // Lookup compare
    logic [WAYS-1:0] lk_vec;
    xlate_tlb_match #(.WAYS(WAYS)) u_lk_match (
        .ents(ent_q[lk_set]), .vpn(lk_vpn), .hit_vec(lk_vec)
    );

    // Invalidation compare
    logic [WAYS-1:0] iv_vec;
    xlate_tlb_match #(.WAYS(WAYS)) u_iv_match (
        .ents(ent_q[iv_set]), .vpn(inv_vpn), .hit_vec(iv_vec)
    );

    // Lowest matching way and match count
    logic [WAY_W-1:0] lk_way;
    logic [CNT_W-1:0] lk_cnt;
    always_comb begin
        lk_way = '0;
        lk_cnt = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lk_vec[w]) begin
                lk_way = WAY_W'(w);
                lk_cnt = lk_cnt + 1'b1;
            end
        end
    end

    logic lk_touch;
    assign lk_touch = lookup_req && (|lk_vec);

    // Recency: lookup hit first, then fill in the same set
    logic [WAYS-1:0][WAY_W-1:0] age_lk, age_fl_in, age_fl;
    xlate_tlb_age #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age_lk (
        .age_in(age_q[lk_set]), .touch(lk_touch), .way(lk_way), .age_out(age_lk)
    );

    assign age_fl_in = (lk_touch && (lk_set == fl_set)) ? age_lk : age_q[fl_set];

    // Victim choice
    logic [WAYS-1:0]  fl_valid_vec;
    logic [WAY_W-1:0] vic_way;
    logic             vic_rr;
    always_comb begin
        for (int w = 0; w < WAYS; w++)
            fl_valid_vec[w] = ent_q[fl_set][w].valid;
    end

    xlate_tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid_vec(fl_valid_vec), .ages(age_fl_in), .lru_mode(cfg_lru),
        .rr_ptr(st_q.rr), .way(vic_way), .use_rr(vic_rr)
    );

    logic fill_ok;
    assign fill_ok = fill_req && (size_e'(fill_size) != SZ_RSVD) && !inv_all;

    xlate_tlb_age #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age_fl (
        .age_in(age_fl_in), .touch(fill_ok), .way(vic_way), .age_out(age_fl)
    );

    // Physical address composition
    entry_t           lk_ent;
    logic [VPN_W-1:0] lk_mask;
    logic [VPN_W-1:0] lk_frame;
    assign lk_ent   = ent_q[lk_set][lk_way];
    assign lk_mask  = size_mask(lk_ent.size);
    assign lk_frame = (lk_ent.pfn & lk_mask) | (lk_vpn & ~lk_mask);

    // Next-state computation
    always_comb begin
        entry_t     new_ent;
        logic [VPN_W-1:0] fmask;

        st_d  = st_q;
        ent_d = ent_q;
        age_d = age_q;

        fmask         = size_mask(size_e'(fill_size));
        new_ent.valid = 1'b1;
        new_ent.size  = size_e'(fill_size);
        new_ent.tag   = fill_vpn & fmask;
        new_ent.pfn   = fill_pfn & fmask;

        // lookup result reflects the pre-update array (R11)
        st_d.valid = lookup_req;
        st_d.hit   = lk_touch;
        st_d.multi = lookup_req && (lk_cnt > CNT_W'(1));
        st_d.pa    = lk_touch ? {lk_frame, lookup_va[OFF_W-1:0]} : '0;

        age_d[lk_set] = age_lk;
        age_d[fl_set] = age_fl;

        if (inv_all) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    ent_d[s][w].valid = 1'b0;
        end else begin
            if (inv_page) begin
                for (int w = 0; w < WAYS; w++)
                    if (iv_vec[w]) ent_d[iv_set][w].valid = 1'b0;
            end
            if (fill_ok) begin
                ent_d[fl_set][vic_way] = new_ent;
                if (vic_rr) st_d.rr = st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    ent_q[s][w] <= '0;
                    age_q[s][w] <= WAY_W'(w);
                end
        end else begin
            st_q  <= st_d;
            ent_q <= ent_d;
            age_q <= age_d;
        end
    end

    assign lk_valid = st_q.valid;
    assign lk_hit   = st_q.hit;
    assign lk_multi = st_q.multi;
    assign lk_pa    = st_q.pa;
endmodule

// File: rtl/xlate_tlb_chk.sv
module xlate_tlb_chk
    import xlate_tlb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             lookup_req,
    input logic [VA_W-1:0]  lookup_va,
    input logic             lk_valid,
    input logic             lk_hit,
    input logic             lk_multi,
    input logic             fill_req,
    input logic             inv_all,
    input logic             inv_page,
    input logic [VPN_W-1:0] inv_vpn
);
    // R1: quiet outputs after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!lk_valid && !lk_hit && !lk_multi));

    // R2: result flag follows the request by exactly one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        lookup_req |=> lk_valid);
    a_r2_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !lookup_req |=> !lk_valid);

    // R5: a multi-hit is always also a hit
    a_r5_multi_is_hit: assert property (@(posedge clk) disable iff (rst)
        lk_multi |-> (lk_hit && lk_valid));

    // R7: lookup in the cycle after a full clear always misses
    a_r7_clear_all: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && $past(inv_all, 2)) |-> !lk_hit);

    // R6: lookup of the exact page invalidated the cycle before misses
    a_r6_page_gone: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && $past(inv_page, 2) && !$past(fill_req, 2) &&
         ($past(inv_vpn, 2) == $past(lookup_va[VA_W-1:OFF_W], 1))) |-> !lk_hit);
endmodule

bind xlate_tlb xlate_tlb_chk u_chk (.*);

// File: tb/xlate_tlb_bench.sv
`timescale 1ns/1ps
module xlate_tlb_bench;
    import xlate_tlb_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_lru;
    logic             lookup_req;
    logic [31:0]      lookup_va;
    logic             lk_valid, lk_hit, lk_multi;
    logic [31:0]      lk_pa;
    logic             fill_req;
    logic [19:0]      fill_vpn, fill_pfn;
    logic [1:0]       fill_size;
    logic             inv_all, inv_page;
    logic [19:0]      inv_vpn;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    xlate_tlb u_xlate_tlb (
        .clk(clk), .rst(rst), .cfg_lru(cfg_lru),
        .lookup_req(lookup_req), .lookup_va(lookup_va),
        .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_pa(lk_pa),
        .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_size(fill_size), .inv_all(inv_all), .inv_page(inv_page),
        .inv_vpn(inv_vpn)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lookup_req = 0; lookup_va = '0; fill_req = 0; fill_vpn = '0;
        fill_pfn = '0; fill_size = '0; inv_all = 0; inv_page = 0; inv_vpn = '0;
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic reset_dut(input bit lru);
        idle_inputs();
        cfg_lru = lru;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
        fill_req = 1; fill_vpn = va[31:12]; fill_pfn = pa[31:12]; fill_size = sz;
        step();
    endtask

    task automatic inv_pg(input logic [31:0] va);
        inv_page = 1; inv_vpn = va[31:12];
        step();
    endtask

    task automatic look(input logic [31:0] va, input bit eh, input bit em,
                        input logic [31:0] epa, input string req);
        lookup_req = 1; lookup_va = va;
        step();
        chk(lk_valid == 1'b1, req, {31'd0, lk_valid}, 32'd1);
        chk(lk_hit == eh, req, {31'd0, lk_hit}, {31'd0, eh});
        chk(lk_multi == em, req, {31'd0, lk_multi}, {31'd0, em});
        if (eh) chk(lk_pa == epa, req, lk_pa, epa);
    endtask

    function automatic logic [31:0] kva(input int k, input int set);
        return (32'(k) << 18) | (32'(set) << 12);
    endfunction
    function automatic logic [31:0] kpa(input int k);
        return 32'h1000_0000 + (32'(k) << 12);
    endfunction

    task automatic t_reset();
        reset_dut(1);
        chk(!lk_valid && !lk_hit && !lk_multi, "R1", {29'd0, lk_valid, lk_hit, lk_multi}, 32'd0);
        look(32'h1234_5678, 0, 0, 0, "R1");
        step();
        chk(lk_valid == 1'b0, "R2", {31'd0, lk_valid}, 32'd0);
    endtask

    task automatic t_sizes();
        reset_dut(1);
        fill(32'h1234_5000, 32'hABCD_E000, 2'd0);
        look(32'h1234_5678, 1, 0, 32'hABCD_E678, "R2");
        look(32'h1234_6678, 0, 0, 0, "R2");
        fill(32'h0001_3000, 32'h7770_0000, 2'd1);
        look(32'h0001_3ABC, 1, 0, 32'h7770_3ABC, "R2");
        look(32'h0001_0ABC, 0, 0, 0, "R3");
        fill(32'h0052_5000, 32'h3000_0000, 2'd2);
        look(32'h005E_5123, 1, 0, 32'h300E_5123, "R3");
        look(32'h0050_0123, 0, 0, 0, "R3");
        fill(32'h00AA_A000, 32'h5000_0000, 2'd3);
        look(32'h00AA_A000, 0, 0, 0, "R4");
    endtask

    task automatic t_multi_inv();
        reset_dut(1);
        fill(32'h0004_2000, 32'h1111_1000, 2'd0);
        fill(32'h0004_2000, 32'h2222_0000, 2'd1);
        look(32'h0004_2010, 1, 1, 32'h1111_1010, "R5");
        inv_pg(32'h0004_2000);
        look(32'h0004_2010, 0, 0, 0, "R6");
        fill(32'h0004_5000, 32'h5550_0000, 2'd1);
        inv_pg(32'h0004_6000);
        look(32'h0004_5000, 1, 0, 32'h5550_5000, "R6");
    endtask

    task automatic t_flush_sect();
        reset_dut(1);
        fill(32'h0050_0000, 32'h4000_0000, 2'd2);
        fill(32'h0052_5000, 32'h4000_0000, 2'd2);
        for (int i = 0; i < 64; i++) begin
            inv_pg(32'h0050_0000 + 32'(i) * 32'h1000);
            if (i == 15) look(32'h0052_5000, 1, 0, 32'h4002_5000, "R12");
        end
        look(32'h0050_0000, 0, 0, 0, "R12");
        look(32'h0052_5000, 0, 0, 0, "R12");
    endtask

    task automatic t_inv_all();
        reset_dut(1);
        fill(32'h0000_1000, 32'h0100_0000, 2'd0);
        fill(32'h0002_2000, 32'h0200_0000, 2'd1);
        fill(32'h0030_0000, 32'h0300_0000, 2'd2);
        inv_all = 1; fill_req = 1; fill_vpn = 20'h00044; fill_pfn = 20'h04000; fill_size = 0;
        step();
        look(32'h0000_1000, 0, 0, 0, "R7");
        look(32'h0002_2000, 0, 0, 0, "R7");
        look(32'h0030_0000, 0, 0, 0, "R7");
        look(32'h0004_4000, 0, 0, 0, "R7");
    endtask

    task automatic t_free_first();
        reset_dut(1);
        for (int k = 1; k <= 8; k++) fill(kva(k, 7), kpa(k), 2'd0);
        inv_pg(kva(3, 7));
        fill(kva(9, 7), kpa(9), 2'd0);
        for (int k = 1; k <= 9; k++)
            if (k != 3) look(kva(k, 7), 1, 0, kpa(k), "R8");
    endtask

    task automatic t_lru();
        reset_dut(1);
        for (int k = 1; k <= 8; k++) fill(kva(k, 9), kpa(k), 2'd0);
        look(kva(1, 9), 1, 0, kpa(1), "R9");
        fill(kva(9, 9), kpa(9), 2'd0);
        look(kva(2, 9), 0, 0, 0, "R9");
        look(kva(1, 9), 1, 0, kpa(1), "R9");
        look(kva(9, 9), 1, 0, kpa(9), "R9");
    endtask

    task automatic t_rr();
        reset_dut(0);
        for (int k = 1; k <= 8; k++) fill(kva(k, 11), kpa(k), 2'd0);
        look(kva(1, 11), 1, 0, kpa(1), "R10");
        fill(kva(9, 11), kpa(9), 2'd0);
        look(kva(1, 11), 0, 0, 0, "R10");
        look(kva(2, 11), 1, 0, kpa(2), "R10");
        fill(kva(10, 11), kpa(10), 2'd0);
        look(kva(2, 11), 0, 0, 0, "R10");
        look(kva(3, 11), 1, 0, kpa(3), "R10");
    endtask

    task automatic t_same_cycle();
        reset_dut(1);
        fill(32'h0007_7000, 32'h9000_0000, 2'd0);
        lookup_req = 1; lookup_va = 32'h0007_7004; inv_page = 1; inv_vpn = 20'h00077;
        step();
        chk(lk_hit && lk_pa == 32'h9000_0004, "R11", lk_pa, 32'h9000_0004);
        look(32'h0007_7004, 0, 0, 0, "R11");
        lookup_req = 1; lookup_va = 32'h0008_8000;
        fill_req = 1; fill_vpn = 20'h00088; fill_pfn = 20'h91000; fill_size = 0;
        step();
        chk(!lk_hit, "R11", {31'd0, lk_hit}, 32'd0);
        look(32'h0008_8000, 1, 0, 32'h9100_0000, "R11");
        inv_page = 1; inv_vpn = 20'h00088;
        fill_req = 1; fill_vpn = 20'h00088; fill_pfn = 20'h92000; fill_size = 0;
        step();
        look(32'h0008_8008, 1, 0, 32'h9200_0008, "R11");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_lru = 1'b1; idle_inputs();
        t_reset();
        t_sizes();
        t_multi_inv();
        t_flush_sect();
        t_inv_all();
        t_free_first();
        t_lru();
        t_rr();
        t_same_cycle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule